// File: doc/BRIEF.md
# Powerline Pulse-Interval Frame Decoder

This block rebuilds command frames received from a powerline carrier modem whose receive line pulses only in the half-cycles of the mains that carry a 1. It never samples every half-cycle. It measures the time between successive accepted pulses in microsecond ticks and decodes each data bit from two things: that interval, counted in half-cycles, and the value of the bit before it. Because every data bit is sent once in true form and once complemented on the following half-cycle, each bit produces exactly one pulse. Where that pulse falls, relative to the previous one, identifies the bit.

A frame opens with three pulses one half-cycle apart. The fourth start position is always empty, so the decoder assumes it and does not wait for it. Nine data bits follow. The upper four form the house pattern and the lower five the key pattern, and each pattern is translated back to its index. When the frame completes, the block emits a one-clock record made of two flag bits, a house index and a key index. Frames that are malformed, or that go silent part-way through, end in an error record. A lone isolated pulse is dropped without producing any record.

Top module: `plc_frame_decoder`

## Requirements
- R1: After reset, `rec_valid` is 0 and `rec_flags`, `rec_house` and `rec_key` are all 0.
- R2: A pulse while idle opens a frame. The second and third accepted pulses must each arrive more than HALF-TOL and fewer than HALF+TOL ticks after the previous accepted pulse, where TOL = HALF/6. Any other interval at that point ends the frame with an error record, emitted in the cycle after the offending pulse.
- R3: In the data phase, when the previous bit was 1, an interval near 2 half-cycles decodes as 1 and an interval near 3 half-cycles decodes as 0. The start pattern counts as ending in a 1. "Near k" means strictly inside k*HALF±TOL.
- R4: In the data phase, when the previous bit was 0, an interval near 1 half-cycle decodes as 1 and an interval near 2 half-cycles decodes as 0.
- R5: A data-phase interval that falls in none of the accepted windows ends the frame with an error record in the cycle after that pulse.
- R6: A pulse that arrives fewer than MIN_GAP ticks after the last accepted pulse, while a frame is open, is ignored for decoding. The next interval is still measured from the last accepted pulse.
- R7: The house index comes from data bits [8:5], where bit 8 is the first bit received. With pattern p, index = {L, p[3]}, where L for p[2:0] = 0..7 is 6,2,1,5,7,3,0,4.
- R8: The key index comes from data bits [4:0]. An odd pattern p gives 16 + p[4:1]. An even pattern gives the R7 mapping applied to p[4:1].
- R9: `rec_flags[0]` is the value of `tx_busy` at the opening pulse of the frame, and `rec_flags[1]` marks an error record. Every error record has house and key equal to 0.
- R10: If SILENCE ticks pass with no pulse after the last pulse of an open frame, the frame is dropped. An error record is emitted in that cycle only if at least two pulses had been accepted. A single isolated pulse produces no record.
- R11: A pulse that lands in the same cycle as the silence expiry is processed as a pulse, and the expiry is not acted on.
- R12: A frame with nine valid bits emits a record with `rec_flags[1]` = 0 in the cycle after the ninth bit's pulse. `rec_valid` lasts exactly one cycle, and the decoder is idle again in that cycle, ready for a new opening pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pulse | input | 1 | Synchronised receive line; a rising edge is one pulse |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| tx_busy | input | 1 | High while the local transmitter is sending |
| rec_valid | output | 1 | One-cycle strobe marking a new record |
| rec_flags | output | 2 | Bit 1 error, bit 0 arrived during local transmission |
| rec_house | output | 4 | House index 0..15 |
| rec_key | output | 5 | Key index 0..31 |

## Verification
The silence timeout and a pulse arrival are the two functions that can land on the same clock edge. The bench provokes the collision by sending a frame's second pulse exactly SILENCE ticks after its first. Taken alone, the timeout would drop this one-pulse frame without a trace. With the pulse processed first, the interval fails the start window and an error record with flags 2'b10 must appear in the next cycle. The other silence cases are placed a few ticks away from the expiry edge and judged by the exact cycle in which the record does or does not appear.

// File: rtl/plcdec_pkg.sv
package plcdec_pkg;

    localparam int HOUSE_W = 4;
    localparam int KEY_W   = 5;
    localparam int WORD_W  = HOUSE_W + KEY_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2
    } dec_state_e;

    typedef struct packed {
        logic err;
        logic local_tx;
    } rec_flags_t;

    typedef struct packed {
        rec_flags_t          flags;
        logic [HOUSE_W-1:0]  house;
        logic [KEY_W-1:0]    key;
    } rec_t;

    // Pattern to index for a 4-bit house field.
    function automatic logic [HOUSE_W-1:0] house_index(input logic [HOUSE_W-1:0] p);
        logic [2:0] hi;
        case (p[2:0])
            3'd0:    hi = 3'd6;
            3'd1:    hi = 3'd2;
            3'd2:    hi = 3'd1;
            3'd3:    hi = 3'd5;
            3'd4:    hi = 3'd7;
            3'd5:    hi = 3'd3;
            3'd6:    hi = 3'd0;
            default: hi = 3'd4;
        endcase
        return {hi, p[3]};
    endfunction

    // Pattern to index for a 5-bit key field.
    function automatic logic [KEY_W-1:0] key_index(input logic [KEY_W-1:0] p);
        if (p[0])
            return {1'b1, p[4:1]};
        return {1'b0, house_index(p[4:1])};
    endfunction

endpackage

// File: rtl/plcdec_edge.sv
module plcdec_edge (
    input  logic clk,
    input  logic rst,
    input  logic rx_level,
    output logic rx_edge
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= rx_level;
    end

    assign rx_edge = rx_level & ~prev_q;
endmodule

// File: rtl/plcdec_interval.sv
module plcdec_interval #(
    parameter int CW    = 16,
    parameter int LIMIT = 50000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart_gap,
    input  logic          restart_quiet,
    output logic [CW-1:0] gap,
    output logic          expired
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] gap_q;
    logic [CW-1:0] quiet_q;

    // Both counters saturate at LIMIT; a restart counts the current tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            quiet_q <= '0;
        end else begin
            if (restart_gap)             gap_q <= CW'(tick);
            else if (tick && gap_q < LIM) gap_q <= gap_q + 1'b1;

            if (restart_quiet)             quiet_q <= CW'(tick);
            else if (tick && quiet_q < LIM) quiet_q <= quiet_q + 1'b1;
        end
    end

    assign gap     = gap_q;
    assign expired = (quiet_q >= LIM);
endmodule

// File: rtl/plcdec_gapclass.sv
module plcdec_gapclass #(
    parameter int CW      = 16,
    parameter int HALF    = 8333,
    parameter int TOL     = 1388,
    parameter int MIN_GAP = 1500,
    parameter int NWIN    = 3
) (
    input  logic [CW-1:0]   gap,
    output logic [NWIN-1:0] near,
    output logic            too_soon
);
    generate
        for (genvar k = 1; k <= NWIN; k++) begin : g_win
            localparam int LO = k * HALF - TOL;
            localparam int HI = k * HALF + TOL;
            assign near[k-1] = (int'(gap) > LO) && (int'(gap) < HI);
        end
    endgenerate

    assign too_soon = int'(gap) < MIN_GAP;
endmodule

// File: rtl/plc_frame_decoder.sv
module plc_frame_decoder
    import plcdec_pkg::*;
#(
    parameter int HALF_US    = 8333,
    parameter int MIN_GAP_US = 1500,
    parameter int SILENCE_US = 50000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_pulse,
    input  logic                us_tick,
    input  logic                tx_busy,
    output logic                rec_valid,
    output logic [1:0]          rec_flags,
    output logic [HOUSE_W-1:0]  rec_house,
    output logic [KEY_W-1:0]    rec_key
);
    localparam int TOL_US = HALF_US / 6;
    localparam int CW     = $clog2(SILENCE_US + 1);
    localparam int NBW    = $clog2(WORD_W);
    localparam logic [NBW-1:0] LAST_BIT = NBW'(WORD_W - 1);

    logic          rx_edge;
    logic [CW-1:0] gap;
    logic          expired;
    logic [2:0]    near;
    logic          too_soon;
    logic          accept;

    dec_state_e          state_q, state_d;
    logic                second_q, second_d;
    logic [WORD_W-1:0]   bits_q, bits_d;
    logic [NBW-1:0]      nbits_q, nbits_d;
    logic                last_q, last_d;
    logic                local_q, local_d;
    logic                emit;
    rec_t                emit_rec, rec_q, err_rec;
    logic                bit_val, bit_ok;
    logic [WORD_W-1:0]   word;
    logic                rec_valid_q;

    plcdec_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .rx_level (rx_pulse),
        .rx_edge  (rx_edge)
    );

    plcdec_interval #(.CW(CW), .LIMIT(SILENCE_US)) u_timer (
        .clk           (clk),
        .rst           (rst),
        .tick          (us_tick),
        .restart_gap   (accept),
        .restart_quiet (rx_edge),
        .gap           (gap),
        .expired       (expired)
    );

    plcdec_gapclass #(
        .CW(CW), .HALF(HALF_US), .TOL(TOL_US), .MIN_GAP(MIN_GAP_US), .NWIN(3)
    ) u_class (
        .gap      (gap),
        .near     (near),
        .too_soon (too_soon)
    );

    always_comb begin
        err_rec                = '0;
        err_rec.flags.err      = 1'b1;
        err_rec.flags.local_tx = local_q;
    end

    always_comb begin
        state_d  = state_q;
        second_d = second_q;
        bits_d   = bits_q;
        nbits_d  = nbits_q;
        last_d   = last_q;
        local_d  = local_q;
        accept   = 1'b0;
        emit     = 1'b0;
        emit_rec = '0;
        bit_val  = 1'b0;
        bit_ok   = 1'b0;
        word     = {bits_q[WORD_W-2:0], 1'b0};

        unique case (state_q)
            ST_IDLE: begin
                if (rx_edge) begin
                    accept   = 1'b1;
                    state_d  = ST_START;
                    second_d = 1'b0;
                    local_d  = tx_busy;
                end
            end
            ST_START: begin
                // A pulse takes priority over a coinciding silence expiry.
                if (rx_edge) begin
                    if (!too_soon) begin
                        if (near[0]) begin
                            accept = 1'b1;
                            if (second_q) begin
                                state_d = ST_DATA;
                                last_d  = 1'b1;
                                nbits_d = '0;
                                bits_d  = '0;
                            end else begin
                                second_d = 1'b1;
                            end
                        end else begin
                            emit     = 1'b1;
                            emit_rec = err_rec;
                            state_d  = ST_IDLE;
                        end
                    end
                end else if (expired) begin
                    state_d = ST_IDLE;
                    if (second_q) begin
                        emit     = 1'b1;
                        emit_rec = err_rec;
                    end
                end
            end
            ST_DATA: begin
                if (rx_edge) begin
                    if (!too_soon) begin
                        accept = 1'b1;
                        if (last_q) begin
                            bit_ok  = near[1] | near[2];
                            bit_val = near[1];
                        end else begin
                            bit_ok  = near[0] | near[1];
                            bit_val = near[0];
                        end
                        word = {bits_q[WORD_W-2:0], bit_val};
                        if (!bit_ok) begin
                            emit     = 1'b1;
                            emit_rec = err_rec;
                            state_d  = ST_IDLE;
                        end else begin
                            bits_d  = word;
                            last_d  = bit_val;
                            nbits_d = nbits_q + 1'b1;
                            if (nbits_q == LAST_BIT) begin
                                emit                    = 1'b1;
                                emit_rec.flags.err      = 1'b0;
                                emit_rec.flags.local_tx = local_q;
                                emit_rec.house = house_index(word[WORD_W-1:KEY_W]);
                                emit_rec.key   = key_index(word[KEY_W-1:0]);
                                state_d        = ST_IDLE;
                            end
                        end
                    end
                end else if (expired) begin
                    emit     = 1'b1;
                    emit_rec = err_rec;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            second_q    <= 1'b0;
            bits_q      <= '0;
            nbits_q     <= '0;
            last_q      <= 1'b0;
            local_q     <= 1'b0;
            rec_valid_q <= 1'b0;
            rec_q       <= '0;
        end else begin
            state_q     <= state_d;
            second_q    <= second_d;
            bits_q      <= bits_d;
            nbits_q     <= nbits_d;
            last_q      <= last_d;
            local_q     <= local_d;
            rec_valid_q <= emit;
            if (emit) rec_q <= emit_rec;
        end
    end

    assign rec_valid = rec_valid_q;
    assign rec_flags = rec_q.flags;
    assign rec_house = rec_q.house;
    assign rec_key   = rec_q.key;
endmodule

// File: rtl/plc_frame_decoder_chk.sv
module plc_frame_decoder_chk
    import plcdec_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rx_edge,
    input logic        too_soon,
    input dec_state_e  state,
    input logic        rec_valid,
    input logic [1:0]  rec_flags,
    input logic [3:0]  rec_house,
    input logic [4:0]  rec_key
);
    assert_strobe_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);

    assert_err_fields_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_flags[1]) |-> (rec_house == 4'd0 && rec_key == 5'd0));

    assert_clean_after_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_flags[1]) |-> $past(rx_edge));

    assert_silence_is_error_R10: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !$past(rx_edge)) |-> rec_flags[1]);

    assert_soon_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && rx_edge && too_soon) |=> (!rec_valid && state == $past(state)));
endmodule

bind plc_frame_decoder plc_frame_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_edge   (rx_edge),
    .too_soon  (too_soon),
    .state     (state_q),
    .rec_valid (rec_valid),
    .rec_flags (rec_flags),
    .rec_house (rec_house),
    .rec_key   (rec_key)
);

// File: tb/plc_frame_decoder_tb.sv
module plc_frame_decoder_tb;
    localparam int H   = 60;
    localparam int MG  = 12;
    localparam int SIL = 360;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx = 1'b0;
    logic tick = 1'b1;
    logic busy = 1'b0;
    logic       rec_valid;
    logic [1:0] rec_flags;
    logic [3:0] rec_house;
    logic [4:0] rec_key;

    int n_chk = 0;
    int n_fail = 0;
    int nrec = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    plc_frame_decoder #(.HALF_US(H), .MIN_GAP_US(MG), .SILENCE_US(SIL)) u_dut (
        .clk(clk), .rst(rst), .rx_pulse(rx), .us_tick(tick), .tx_busy(busy),
        .rec_valid(rec_valid), .rec_flags(rec_flags),
        .rec_house(rec_house), .rec_key(rec_key)
    );

    always @(negedge clk) if (rec_valid) nrec++;

    // {busy, jitter select, house, key}; jitter 0:0, 1:+9, 2:-9 ticks per interval
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 2'd0, 4'd0,  5'd0},
        {1'b0, 2'd1, 4'd15, 5'd31},
        {1'b0, 2'd2, 4'd6,  5'd16},
        {1'b0, 2'd0, 4'd9,  5'd21},
        {1'b1, 2'd0, 4'd12, 5'd12},
        {1'b0, 2'd1, 4'd3,  5'd28},
        {1'b1, 2'd2, 4'd10, 5'd7},
        {1'b1, 2'd1, 4'd5,  5'd25}
    };

    function automatic logic [3:0] house_pat(input int idx);
        case (idx)
            0: return 4'b0110;  1: return 4'b1110;  2: return 4'b0010;  3: return 4'b1010;
            4: return 4'b0001;  5: return 4'b1001;  6: return 4'b0101;  7: return 4'b1101;
            8: return 4'b0111;  9: return 4'b1111; 10: return 4'b0011; 11: return 4'b1011;
            12: return 4'b0000; 13: return 4'b1000; 14: return 4'b0100; default: return 4'b1100;
        endcase
    endfunction

    function automatic logic [4:0] key_pat(input int idx);
        if (idx >= 16) return {4'(idx - 16), 1'b1};
        return {house_pat(idx), 1'b0};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entered at a negedge one half cycle after the previous pulse edge.
    task automatic pulse_after(input int g);
        repeat (g - 1) @(negedge clk);
        rx = 1'b1;
        @(negedge clk);
        rx = 1'b0;
    endtask

    task automatic first_pulse();
        @(negedge clk);
        rx = 1'b1;
        @(negedge clk);
        rx = 1'b0;
    endtask

    task automatic send_frame(input int h, input int k, input bit b, input int j, input int glitch);
        logic [8:0] d;
        int prev;
        d = {house_pat(h), key_pat(k)};
        busy = b;
        first_pulse();
        pulse_after(H + j);
        pulse_after(H + j);
        prev = 2;
        for (int i = 0; i < 9; i++) begin
            int slot;
            int g;
            slot = 4 + 2 * i + (d[8 - i] ? 0 : 1);
            g = (slot - prev) * H + j;
            if (i == glitch) begin
                pulse_after(5);
                pulse_after(g - 5);
            end else begin
                pulse_after(g);
            end
            prev = slot;
        end
        busy = 1'b0;
    endtask

    task automatic wait_rec(output int waited);
        waited = 0;
        while (!rec_valid && waited < SIL + 20) begin
            @(negedge clk);
            waited++;
        end
    endtask

    initial begin
        repeat (SIL * 400) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int w;
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", rec_valid, 0);
        chk("R1 fields", {rec_flags, rec_house, rec_key}, 0);

        // R3 R4 R7 R8 R9 R12: table of frames, decoded through the interval rules
        foreach (VEC[v]) begin
            int jj;
            jj = (VEC[v][10:9] == 2'd1) ? 9 : (VEC[v][10:9] == 2'd2) ? -9 : 0;
            send_frame(VEC[v][8:5], VEC[v][4:0], VEC[v][11], jj, 99);
            chk("R12 valid", rec_valid, 1);
            chk("R9 flags", rec_flags, {1'b0, VEC[v][11]});
            chk("R7 house", rec_house, VEC[v][8:5]);
            chk("R8 key", rec_key, VEC[v][4:0]);
            @(negedge clk);
            chk("R12 one cycle", rec_valid, 0);
            repeat (3) @(negedge clk);
        end

        // R6: early pulse inside a data bit interval is ignored
        send_frame(2, 5, 1'b0, 0, 4);
        chk("R6 valid", rec_valid, 1);
        chk("R6 house", rec_house, 2);
        chk("R6 key", rec_key, 5);
        repeat (4) @(negedge clk);

        // R2: second pulse two half-cycles late
        first_pulse();
        pulse_after(2 * H);
        chk("R2 second gap err", rec_valid, 1);
        chk("R2 flags", rec_flags, 2);
        chk("R9 err house", rec_house, 0);
        chk("R9 err key", rec_key, 0);
        repeat (4) @(negedge clk);

        // R2: third pulse off window
        first_pulse();
        pulse_after(H);
        pulse_after(30);
        chk("R2 third gap err", rec_valid, 1);
        chk("R2 third flags", rec_flags, 2);
        repeat (4) @(negedge clk);

        // R5 R9: bad data interval during local transmission
        busy = 1'b1;
        first_pulse();
        busy = 1'b0;
        pulse_after(H);
        pulse_after(H);
        pulse_after(90);
        chk("R5 bad data valid", rec_valid, 1);
        chk("R5 R9 flags", rec_flags, 3);
        repeat (4) @(negedge clk);

        // R10: isolated pulse dropped silently
        n0 = nrec;
        first_pulse();
        repeat (SIL + 20) @(negedge clk);
        chk("R10 lone pulse", nrec - n0, 0);

        // R10: two pulses then silence
        first_pulse();
        pulse_after(H);
        wait_rec(w);
        chk("R10 expiry cycle", w, SIL);
        chk("R10 flags", rec_flags, 2);
        repeat (4) @(negedge clk);

        // R10: silence during data phase
        first_pulse();
        pulse_after(H);
        pulse_after(H);
        pulse_after(3 * H);
        wait_rec(w);
        chk("R10 data expiry cycle", w, SIL);
        chk("R10 data flags", rec_flags, 2);
        repeat (4) @(negedge clk);

        // R11: pulse on the expiry edge is handled as a pulse
        n0 = nrec;
        first_pulse();
        pulse_after(SIL);
        chk("R11 pulse wins", rec_valid, 1);
        chk("R11 flags", rec_flags, 2);
        repeat (SIL + 20) @(negedge clk);
        chk("R11 single record", nrec - n0, 1);

        // R12: decoder idle again, next frame decodes
        send_frame(14, 19, 1'b0, 0, 99);
        chk("R12 after errors", rec_valid, 1);
        chk("R7 house final", rec_house, 14);
        chk("R8 key final", rec_key, 19);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule